// File: doc/BRIEF.md
# Secondary Interrupt Handler Bank

This block collects up to 24 level inputs from surrounding logic and turns selected transitions on them into latched interrupt events. Every source has its own two-bit trigger field that arms a rising edge, a falling edge, both, or neither. The trigger configuration is a single copy. Each detected event is latched into two independent status views, one per host. Each view has its own mask and drives its own active-low request pin, so two hosts can serve the same sources without touching each other's pending state.

Software reaches all state through a byte-wide register port with a single-cycle write strobe and a read strobe whose data appears one clock later. A control byte selects how status is acknowledged: by writing ones, or automatically by reading the status byte. It also selects whether a second event that arrives on a still-pending source is kept for later. Test software can force status bits through a write-only set register.

The register map uses a 4-byte stride per register. The map is: line-0 status 0x00, line-0 mask 0x04, line-0 set 0x08, line-1 status 0x0C, line-1 mask 0x10, line-1 set 0x14, trigger bytes from 0x18, control 0x1F. Multi-byte registers hold the least significant byte at the lowest address. Bytes beyond the configured source count read zero.

Top module: `sih_bank`

## Requirements
- R1: After reset both request pins are high, both masks read all ones for implemented sources, status reads zero, trigger bytes read zero and the control byte reads zero.
- R2: Trigger byte b at address 0x18+b holds the fields of sources 4b..4b+3. For source k, bit 2k+1 of the packed trigger vector arms rising-edge detection and bit 2k arms falling-edge detection.
- R3: A source whose two trigger bits are both zero never sets a status bit from its input, whatever the input does.
- R4: Request pin L is low one clock after status_L & ~mask_L is nonzero, and high one clock after it is zero.
- R5: One input event sets the matching status bit in both lines. Clearing or masking it in one line leaves the other line unchanged.
- R6: With control bit 0 clear, writing a one to a status bit clears it. Writing zero and reading have no effect on status.
- R7: With control bit 0 set, reading a status byte clears exactly the bits it returned, and writes to status are ignored.
- R8: With control bit 1 set, a second event on a source whose status bit is pending is held, and the bit sets again right after it is cleared. With control bit 1 clear, that second event is lost.
- R9: Writing ones to a set register forces those status bits in that line only. A set register reads zero.
- R10: When a status bit is cleared in the same cycle a new event for it is detected, the bit stays set.
- R11: Read data is registered: it appears one clock after the read strobe. Unused bytes and addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NSRC | Asynchronous source levels |
| reg_addr | input | 5 | Register byte address |
| reg_wr | input | 1 | Write strobe, one cycle per byte |
| reg_rd | input | 1 | Read strobe, one cycle per byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the clock after reg_rd |
| int_n | output | 2 | Active-low request, one per host line |

## Verification
Wrong edge-detect or trigger-field decoding shows at the ports four to five clocks after an input change. It appears as a status byte whose set bits differ from the armed fields. A pending-buffer or clear-priority fault stays hidden until the first acknowledge. It then appears as a bit that does or does not come back on the very next status read. A mask or request fault reaches int_n one clock after the mask or status register changes. A clear-mode fault shows up on the second of two back-to-back reads of the same status byte.

// File: rtl/sih_pkg.sv
package sih_pkg;
  localparam int ADDR_W = 5;
  localparam logic [4:0] A_STAT0 = 5'h00;
  localparam logic [4:0] A_MASK0 = 5'h04;
  localparam logic [4:0] A_SET0  = 5'h08;
  localparam logic [4:0] A_STAT1 = 5'h0C;
  localparam logic [4:0] A_MASK1 = 5'h10;
  localparam logic [4:0] A_SET1  = 5'h14;
  localparam logic [4:0] A_TRIG  = 5'h18;
  localparam logic [4:0] A_CTRL  = 5'h1F;
  localparam int CTRL_COR  = 0;
  localparam int CTRL_HOLD = 1;
endpackage

// File: rtl/sih_sync.sv
module sih_sync #(
  parameter int NSRC = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_in,
  input  logic [2*NSRC-1:0] trig,
  output logic [NSRC-1:0]   ev
);
  logic [NSRC-1:0] meta_q, lvl_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= src_in;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_det
    assign ev[i] = (lvl_q[i] & ~prev_q[i] & trig[2*i+1])
                 | (~lvl_q[i] & prev_q[i] & trig[2*i]);
  end
endmodule

// File: rtl/sih_line.sv
module sih_line #(
  parameter int         NSRC = 12,
  parameter logic [4:0] A_ST = 5'h00,
  parameter logic [4:0] A_MK = 5'h04,
  parameter logic [4:0] A_SE = 5'h08
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] ev,
  input  logic            cor,
  input  logic            hold,
  input  logic [4:0]      addr,
  input  logic            wr,
  input  logic            rd,
  input  logic [7:0]      wdata,
  output logic [NSRC-1:0] stat,
  output logic [NSRC-1:0] mask,
  output logic            int_n
);
  logic [NSRC-1:0] pend, clr, setf, mwr, ev_all, stat_n, pend_n;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    localparam logic [4:0] OFS = 5'(i / 8);
    logic hit_st;
    assign hit_st  = (addr == A_ST + OFS);
    assign clr[i]  = cor ? (rd & hit_st & stat[i]) : (wr & hit_st & wdata[i % 8]);
    assign setf[i] = wr & (addr == A_SE + OFS) & wdata[i % 8];
    assign mwr[i]  = wr & (addr == A_MK + OFS);
  end

  assign ev_all = ev | setf;
  assign stat_n = (stat & ~clr) | ev_all | (pend & clr);
  assign pend_n = hold ? ((pend & ~clr) | (ev_all & stat & ~clr)) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat  <= '0;
      pend  <= '0;
      mask  <= '1;
      int_n <= 1'b1;
    end else begin
      stat  <= stat_n;
      pend  <= pend_n;
      int_n <= ~|(stat & ~mask);
      for (int i = 0; i < NSRC; i++)
        if (mwr[i]) mask[i] <= wdata[i % 8];
    end
  end

  // R1: state right after reset release
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask == '1) && (stat == '0) && int_n);

  // R8: a held event exists only behind a pending status bit
  a_r8_pend_behind_stat: assert property (@(posedge clk) disable iff (rst)
    (pend & ~stat) == '0);

  // R6: in write-clear mode a read leaves status untouched
  a_r6_read_no_clear: assert property (@(posedge clk) disable iff (rst)
    (!cor && rd && !wr && ev == '0) |=> stat == $past(stat));

  // R9: forcing bit 0 through the set register latches it
  a_r9_set_forces: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == A_SE && wdata[0]) |=> stat[0]);
endmodule

// File: rtl/sih_bank.sv
module sih_bank
  import sih_pkg::*;
#(
  parameter int NSRC = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_in,
  input  logic [4:0]      reg_addr,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  output logic [1:0]      int_n
);
  localparam int TW = 2 * NSRC;

  logic [TW-1:0]   trig;
  logic [1:0]      ctrl;
  logic [NSRC-1:0] ev, en_any;
  logic [NSRC-1:0] stat_q [2];
  logic [NSRC-1:0] mask_q [2];
  logic [31:0]     st0p, st1p, mk0p, mk1p;
  logic [63:0]     trp;
  logic [7:0]      rd_byte;

  initial assert (NSRC >= 1 && NSRC <= 24);

  sih_sync #(.NSRC(NSRC)) u_sync (
    .clk(clk), .rst(rst), .src_in(src_in), .trig(trig), .ev(ev)
  );

  for (genvar l = 0; l < 2; l++) begin : g_line
    localparam logic [4:0] ST = (l == 0) ? A_STAT0 : A_STAT1;
    localparam logic [4:0] MK = (l == 0) ? A_MASK0 : A_MASK1;
    localparam logic [4:0] SE = (l == 0) ? A_SET0  : A_SET1;
    sih_line #(.NSRC(NSRC), .A_ST(ST), .A_MK(MK), .A_SE(SE)) u_line (
      .clk(clk), .rst(rst), .ev(ev),
      .cor(ctrl[CTRL_COR]), .hold(ctrl[CTRL_HOLD]),
      .addr(reg_addr), .wr(reg_wr), .rd(reg_rd), .wdata(reg_wdata),
      .stat(stat_q[l]), .mask(mask_q[l]), .int_n(int_n[l])
    );
  end

  for (genvar j = 0; j < TW; j++) begin : g_trig
    localparam logic [4:0] TA = A_TRIG + 5'(j / 8);
    always_ff @(posedge clk) begin
      if (rst) trig[j] <= 1'b0;
      else if (reg_wr && reg_addr == TA) trig[j] <= reg_wdata[j % 8];
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_en
    assign en_any[i] = trig[2*i] | trig[2*i+1];
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl <= '0;
    else if (reg_wr && reg_addr == A_CTRL) ctrl <= reg_wdata[1:0];
  end

  assign st0p = 32'(stat_q[0]);
  assign st1p = 32'(stat_q[1]);
  assign mk0p = 32'(mask_q[0]);
  assign mk1p = 32'(mask_q[1]);
  assign trp  = 64'(trig);

  always_comb begin
    rd_byte = '0;
    case (reg_addr[4:2])
      3'd0: rd_byte = st0p[{reg_addr[1:0], 3'b000} +: 8];
      3'd1: rd_byte = mk0p[{reg_addr[1:0], 3'b000} +: 8];
      3'd3: rd_byte = st1p[{reg_addr[1:0], 3'b000} +: 8];
      3'd4: rd_byte = mk1p[{reg_addr[1:0], 3'b000} +: 8];
      3'd6, 3'd7: begin
        if (reg_addr == A_CTRL) rd_byte = {6'b0, ctrl};
        else rd_byte = trp[{reg_addr[2:0], 3'b000} +: 8];
      end
      default: rd_byte = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_byte;
  end

  // R3: an unarmed source never produces an event
  a_r3_unarmed_silent: assert property (@(posedge clk) disable iff (rst)
    (ev & ~en_any) == '0);
endmodule

// File: tb/sih_bank_test.sv
module sih_bank_test;
  localparam int N = 12;
  logic clk = 1'b0, rst = 1'b1;
  logic [N-1:0] src = '0;
  logic [4:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] int_n;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  sih_bank #(.NSRC(N)) uut (
    .clk(clk), .rst(rst), .src_in(src), .reg_addr(addr), .reg_wr(wr),
    .reg_rd(rd), .reg_wdata(wdata), .reg_rdata(rdata), .int_n(int_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic rd16(input logic [4:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd_reg(a, lo);
    rd_reg(a + 5'd1, hi);
    v = {hi, lo};
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic clr_all();
    wr_reg(5'h00, 8'hFF); wr_reg(5'h01, 8'hFF);
    wr_reg(5'h0C, 8'hFF); wr_reg(5'h0D, 8'hFF);
  endtask

  task automatic set_trig(input logic [7:0] b);
    wr_reg(5'h18, b); wr_reg(5'h19, b); wr_reg(5'h1A, b);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic [15:0] v, v1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 int_n", 32'(int_n), 32'h3);
    rd16(5'h04, v); chk("R1 mask0", 32'(v), 32'h0FFF);
    rd16(5'h10, v); chk("R1 mask1", 32'(v), 32'h0FFF);
    rd16(5'h00, v); chk("R1 stat0", 32'(v), 32'h0);
    rd_reg(5'h18, d); chk("R1 trig0", 32'(d), 32'h0);
    rd_reg(5'h1F, d); chk("R1 ctrl", 32'(d), 32'h0);

    // R3 unarmed sources ignore input toggles
    src = '1; settle(); src = '0; settle();
    rd16(5'h00, v); chk("R3 unarmed stat0", 32'(v), 32'h0);
    rd16(5'h0C, v); chk("R3 unarmed stat1", 32'(v), 32'h0);

    // R2/R3/R5 sweep over the four uniform trigger settings
    for (int c = 0; c < 4; c++) begin
      set_trig({4{c[1:0]}});
      clr_all();
      src = '1; settle();
      rd16(5'h00, v); rd16(5'h0C, v1);
      chk($sformatf("R2 rise cfg%0d line0", c), 32'(v), c[1] ? 32'h0FFF : 32'h0);
      chk($sformatf("R5 rise cfg%0d line1", c), 32'(v1), c[1] ? 32'h0FFF : 32'h0);
      clr_all();
      src = '0; settle();
      rd16(5'h00, v); rd16(5'h0C, v1);
      chk($sformatf("R2 fall cfg%0d line0", c), 32'(v), c[0] ? 32'h0FFF : 32'h0);
      chk($sformatf("R5 fall cfg%0d line1", c), 32'(v1), c[0] ? 32'h0FFF : 32'h0);
      clr_all();
    end

    // R2 field position: source i armed with code i%4
    set_trig(8'hE4);
    rd_reg(5'h18, d); chk("R11 trig readback", 32'(d), 32'hE4);
    for (int i = 0; i < N; i++) begin
      src = N'(1) << i; settle();
      rd16(5'h00, v);
      chk($sformatf("R2 walk rise src%0d", i), 32'(v), ((i % 4) >= 2) ? (32'h1 << i) : 32'h0);
      clr_all();
      src = '0; settle();
      rd16(5'h00, v);
      chk($sformatf("R2 walk fall src%0d", i), 32'(v), ((i % 4) % 2 == 1) ? (32'h1 << i) : 32'h0);
      clr_all();
    end

    // R4 / R5 masks and requests
    set_trig(8'hFF);
    src[3] = 1'b1; settle();
    chk("R4 all masked", 32'(int_n), 32'h3);
    wr_reg(5'h10, 8'hF7); @(negedge clk);
    chk("R4 line1 unmasked", 32'(int_n), 32'h1);
    wr_reg(5'h04, 8'hF7); @(negedge clk);
    chk("R4 both unmasked", 32'(int_n), 32'h0);
    wr_reg(5'h00, 8'h08); @(negedge clk);
    rd16(5'h00, v); chk("R5 line0 cleared", 32'(v), 32'h0);
    rd16(5'h0C, v); chk("R5 line1 kept", 32'(v), 32'h8);
    chk("R4 line0 released", 32'(int_n), 32'h1);

    // R6 write-one-to-clear
    wr_reg(5'h0C, 8'h00);
    rd16(5'h0C, v); chk("R6 zero write no effect", 32'(v), 32'h8);
    rd16(5'h0C, v); chk("R6 read no clear", 32'(v), 32'h8);
    wr_reg(5'h0C, 8'h08); @(negedge clk);
    rd16(5'h0C, v); chk("R6 one clears", 32'(v), 32'h0);
    chk("R4 both released", 32'(int_n), 32'h3);
    src = '0; settle(); clr_all();

    // R9 set register
    wr_reg(5'h09, 8'h05);
    rd16(5'h00, v); chk("R9 forced line0", 32'(v), 32'h0500);
    rd16(5'h0C, v); chk("R9 line1 untouched", 32'(v), 32'h0);
    rd_reg(5'h09, d); chk("R9 set reads zero", 32'(d), 32'h0);

    // R7 clear-on-read
    wr_reg(5'h1F, 8'h01);
    wr_reg(5'h08, 8'h03);
    wr_reg(5'h00, 8'hFF);
    rd_reg(5'h00, d); chk("R7 write ignored, first read", 32'(d), 32'h03);
    rd_reg(5'h00, d); chk("R7 cleared by read", 32'(d), 32'h00);
    rd_reg(5'h01, d); chk("R7 upper byte", 32'(d), 32'h05);
    rd_reg(5'h01, d); chk("R7 upper cleared", 32'(d), 32'h00);
    rd_reg(5'h1F, d); chk("R11 ctrl readback", 32'(d), 32'h01);

    // R8 hold of a second event
    wr_reg(5'h1F, 8'h02); clr_all();
    src[0] = 1'b1; settle(); src[0] = 1'b0; settle();
    rd_reg(5'h00, d); chk("R8 first event", 32'(d), 32'h01);
    wr_reg(5'h00, 8'h01);
    rd_reg(5'h00, d); chk("R8 held event returns", 32'(d), 32'h01);
    wr_reg(5'h00, 8'h01);
    rd_reg(5'h00, d); chk("R8 second clear empties", 32'(d), 32'h00);
    wr_reg(5'h1F, 8'h00); clr_all();
    src[0] = 1'b1; settle(); src[0] = 1'b0; settle();
    wr_reg(5'h00, 8'h01);
    rd_reg(5'h00, d); chk("R8 no hold loses event", 32'(d), 32'h00);

    // R10 clear and event in the same cycle
    clr_all();
    wr_reg(5'h08, 8'h02);
    src[1] = 1'b1;
    @(negedge clk); @(negedge clk);
    wr_reg(5'h00, 8'h02);
    settle();
    rd_reg(5'h00, d); chk("R10 event wins over clear", 32'(d), 32'h02);
    wr_reg(5'h00, 8'h02);
    rd_reg(5'h00, d); chk("R10 plain clear", 32'(d), 32'h00);

    // R11 unused bytes
    rd_reg(5'h02, d); chk("R11 stat byte2 zero", 32'(d), 32'h0);
    rd_reg(5'h1E, d); chk("R11 trig byte6 zero", 32'(d), 32'h0);
    rd_reg(5'h05, d); chk("R11 mask0 upper", 32'(d), 32'h0F);

    finish_run();
  end
endmodule